// File: doc/BRIEF.md
# IRQ/FIQ Interrupt Controller

This block gathers up to 96 interrupt sources, arranged as three 32-bit banks, into sticky pending bits. It then reduces them to two processor-facing lines. A source that is sampled high on a rising clock edge latches its pending bit. The bit stays latched until software clears it by writing a one to it.

Each source has a mask bit that blocks it and a routing bit that steers it onto the fast interrupt line. Every unmasked pending source drives the normal line. An unmasked pending source whose routing bit is set also drives the fast line.

A second bank of pending bits records sources that were captured while routed to the fast line. A handful of plain scratch registers (vector, base, protect, NMI control) and a per-source enable bank complete the register set. None of these scratch registers or enable bits affects the outputs.

Software uses a 32-bit register bus with read strobe, write strobe, byte address, write data, read data and a ready flag. The register window is 0x400 bytes wide.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: A source sampled high on a rising clock edge sets its pending bit at that edge. The bit stays set after the source falls, until software clears it. Source n maps to bit n%32 of pending word n/32.
- R2: A write to an IRQ-pending word (0x10, 0x14, 0x18) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: `irq_o` is high one cycle after any bank holds a bit that is pending with its mask bit at 0. A mask bit of 1 blocks its source. The mask words are at 0x50, 0x54 and 0x58.
- R4: `fiq_o` is high one cycle after any bank holds a bit that is pending, unmasked and has its select bit at 1. The select words are at 0x30, 0x34 and 0x38.
- R5: The vector register (0x00) and the base register (0x04) store written data with bits [1:0] forced to 0. Protect (0x08), NMI control (0x0C), select, enable (0x40, 0x44, 0x48) and mask store and return all 32 bits.
- R6: Within each word group, address bits [3:2] pick the word: values 0, 1 and 2 give words 0, 1 and 2. A write to one word leaves the other words of the group unchanged.
- R7: A FIQ-pending bit (words at 0x20, 0x24, 0x28) is set when its source is sampled high while its select bit is 1. The FIQ-pending bits are readable. Writing ones clears them, independently of the IRQ-pending bits.
- R8: Offset +0xC of any word group, addresses with bits [1:0] not zero, and addresses from 0x60 upward are undecoded. A read there returns 0, and a write there changes no register.
- R9: An active-low reset clears every register and both outputs to 0.
- R10: A read or write strobe sampled on a rising edge makes `bus_rdy` high for the following cycle, with read data valid in that cycle. A write takes effect at that same edge. With no strobe, `bus_rdy` is low.
- R11: If a source is sampled high in the same cycle that software writes a 1 to clear its pending bit, the bit ends up set.
- R12: The enable words have no effect on `irq_o` or `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 96 | Interrupt source levels, sampled each rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 10 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rdy` is high after a read |
| bus_rdy | output | 1 | Access completion, one cycle after a strobe |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
A pending bit lands at the rising edge that samples its source. Either output reacts one edge later, so a source pulse or a mask, select or clear write shows on `irq_o` and `fiq_o` two edges after it is driven. The bench drives inputs on falling edges. After each stimulus it waits exactly one further falling edge before it samples the outputs. Read results arrive with `bus_rdy` in the cycle after the strobe. A scoreboard queue holds the expected value of each access, and a falling-edge monitor pops one entry for every ready cycle, so each read is compared in precisely the cycle it completes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 10;

  // Word-group base offsets; the word index inside a group is addr[3:2]
  localparam logic [ADDR_W-1:0] OFF_SCALAR = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_IPEND  = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_FPEND  = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_SEL    = 10'h030;
  localparam logic [ADDR_W-1:0] OFF_EN     = 10'h040;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 10'h050;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_VEC,
    RG_BASE,
    RG_PROT,
    RG_NMI,
    RG_IPEND,
    RG_FPEND,
    RG_SEL,
    RG_EN,
    RG_MASK
  } reg_grp_e;

  typedef struct packed {
    reg_grp_e   grp;
    logic [1:0] idx;
  } reg_sel_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned NBANK = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          dsel
);

  localparam int unsigned GW = ADDR_W - 4;

  logic idx_ok;

  assign idx_ok = (32'(addr[3:2]) < NBANK);

  always_comb begin
    dsel.grp = RG_NONE;
    dsel.idx = addr[3:2];
    if (addr[1:0] == 2'b00) begin
      case (addr[ADDR_W-1:4])
        OFF_SCALAR[ADDR_W-1:4]: begin
          case (addr[3:2])
            2'd0:    dsel.grp = RG_VEC;
            2'd1:    dsel.grp = RG_BASE;
            2'd2:    dsel.grp = RG_PROT;
            default: dsel.grp = RG_NMI;
          endcase
        end
        OFF_IPEND[ADDR_W-1:4]: if (idx_ok) dsel.grp = RG_IPEND;
        OFF_FPEND[ADDR_W-1:4]: if (idx_ok) dsel.grp = RG_FPEND;
        OFF_SEL[ADDR_W-1:4]:   if (idx_ok) dsel.grp = RG_SEL;
        OFF_EN[ADDR_W-1:4]:    if (idx_ok) dsel.grp = RG_EN;
        OFF_MASK[ADDR_W-1:4]:  if (idx_ok) dsel.grp = RG_MASK;
        default: dsel.grp = RG_NONE;
      endcase
    end
  end

  logic [GW-1:0] unused_gw;
  assign unused_gw = '0;

endmodule

// File: rtl/irqc_pend_word.sv
module irqc_pend_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] route,
  input  logic         iclr_en,
  input  logic         fclr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] ipend_q,
  output logic [W-1:0] fpend_q
);

  logic [W-1:0] ipend_d;
  logic [W-1:0] fpend_d;
  logic         i_ce;
  logic         f_ce;

  // Clear is applied first, capture last: a same-cycle set survives
  always_comb begin
    ipend_d = ipend_q;
    fpend_d = fpend_q;
    if (iclr_en) ipend_d = ipend_d & ~clr_bits;
    if (fclr_en) fpend_d = fpend_d & ~clr_bits;
    ipend_d = ipend_d | src;
    fpend_d = fpend_d | (src & route);
  end

  assign i_ce = iclr_en | (|src);
  assign f_ce = fclr_en | (|(src & route));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipend_q <= '0;
      fpend_q <= '0;
    end else begin
      if (i_ce) ipend_q <= ipend_d;
      if (f_ce) fpend_q <= fpend_d;
    end
  end

endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int unsigned NBANK = 3,
  parameter int unsigned W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBANK-1:0][W-1:0]  ipend,
  input  logic [NBANK-1:0][W-1:0]  mask,
  input  logic [NBANK-1:0][W-1:0]  sel,
  output logic                     irq_o,
  output logic                     fiq_o
);

  logic [NBANK-1:0] irq_any;
  logic [NBANK-1:0] fiq_any;
  logic             irq_d;
  logic             fiq_d;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [W-1:0] live;
    assign live       = ipend[b] & ~mask[b];
    assign irq_any[b] = |live;
    assign fiq_any[b] = |(live & sel[b]);
  end

  always_comb begin
    irq_d = |irq_any;
    fiq_d = |fiq_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NBANK = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*WORD_W-1:0] src_i,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    bus_rdy,
  output logic                    irq_o,
  output logic                    fiq_o
);

  localparam int unsigned NSRC = NBANK * WORD_W;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  reg_sel_t dsel;

  irqc_decode #(.NBANK(NBANK)) u_dec (
    .addr (bus_addr),
    .dsel (dsel)
  );

  // Scalar registers
  logic [WORD_W-1:0] vec_q, vec_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic [WORD_W-1:0] prot_q, prot_d;
  logic [WORD_W-1:0] nmi_q, nmi_d;
  logic              scal_ce;

  always_comb begin
    vec_d  = vec_q;
    base_d = base_q;
    prot_d = prot_q;
    nmi_d  = nmi_q;
    case (dsel.grp)
      RG_VEC:  vec_d  = {bus_wdata[WORD_W-1:2], 2'b00};
      RG_BASE: base_d = {bus_wdata[WORD_W-1:2], 2'b00};
      RG_PROT: prot_d = bus_wdata;
      RG_NMI:  nmi_d  = bus_wdata;
      default: ;
    endcase
  end

  assign scal_ce = bus_wr && (dsel.grp inside {RG_VEC, RG_BASE, RG_PROT, RG_NMI});

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vec_q  <= '0;
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (scal_ce) begin
      vec_q  <= vec_d;
      base_q <= base_d;
      prot_q <= prot_d;
      nmi_q  <= nmi_d;
    end
  end

  // Per-bank configuration words and pending capture
  logic [NBANK-1:0][WORD_W-1:0] sel_q;
  logic [NBANK-1:0][WORD_W-1:0] en_q;
  logic [NBANK-1:0][WORD_W-1:0] mask_q;
  logic [NBANK-1:0][WORD_W-1:0] ipend_w;
  logic [NBANK-1:0][WORD_W-1:0] fpend_w;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              hit;
    logic              sel_we, en_we, mask_we;
    logic              iclr, fclr;
    logic [WORD_W-1:0] sel_r, en_r, mask_r;

    assign hit     = bus_wr && (dsel.idx == 2'(b));
    assign sel_we  = hit && (dsel.grp == RG_SEL);
    assign en_we   = hit && (dsel.grp == RG_EN);
    assign mask_we = hit && (dsel.grp == RG_MASK);
    assign iclr    = hit && (dsel.grp == RG_IPEND);
    assign fclr    = hit && (dsel.grp == RG_FPEND);

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        sel_r  <= '0;
        en_r   <= '0;
        mask_r <= '0;
      end else begin
        if (sel_we)  sel_r  <= bus_wdata;
        if (en_we)   en_r   <= bus_wdata;
        if (mask_we) mask_r <= bus_wdata;
      end
    end

    assign sel_q[b]  = sel_r;
    assign en_q[b]   = en_r;
    assign mask_q[b] = mask_r;

    irqc_pend_word #(.W(WORD_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .src      (src_i[b*WORD_W +: WORD_W]),
      .route    (sel_r),
      .iclr_en  (iclr),
      .fclr_en  (fclr),
      .clr_bits (bus_wdata),
      .ipend_q  (ipend_w[b]),
      .fpend_q  (fpend_w[b])
    );
  end

  irqc_route #(.NBANK(NBANK), .W(WORD_W)) u_route (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ipend (ipend_w),
    .mask  (mask_q),
    .sel   (sel_q),
    .irq_o (irq_o),
    .fiq_o (fiq_o)
  );

  // Read path: registered data and completion flag
  logic [WORD_W-1:0] rd_d;
  logic              rdy_d;

  always_comb begin
    rd_d = '0;
    case (dsel.grp)
      RG_VEC:  rd_d = vec_q;
      RG_BASE: rd_d = base_q;
      RG_PROT: rd_d = prot_q;
      RG_NMI:  rd_d = nmi_q;
      default: ;
    endcase
    for (int b = 0; b < NBANK; b++) begin
      if (dsel.idx == 2'(b)) begin
        case (dsel.grp)
          RG_IPEND: rd_d = ipend_w[b];
          RG_FPEND: rd_d = fpend_w[b];
          RG_SEL:   rd_d = sel_q[b];
          RG_EN:    rd_d = en_q[b];
          RG_MASK:  rd_d = mask_q[b];
          default:  ;
        endcase
      end
    end
  end

  assign rdy_d = bus_rd | bus_wr;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bus_rdata <= '0;
      bus_rdy   <= 1'b0;
    end else begin
      bus_rdy <= rdy_d;
      if (bus_rd) bus_rdata <= rd_d;
    end
  end

  logic [NSRC-1:0] unused_src;
  assign unused_src = src_i;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NBANK = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NBANK*WORD_W-1:0]      src_i,
  input logic                         bus_rd,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [WORD_W-1:0]            bus_rdata,
  input logic                         bus_rdy,
  input logic                         irq_o,
  input logic                         fiq_o,
  input logic [NBANK-1:0][WORD_W-1:0] ipend,
  input logic [NBANK-1:0][WORD_W-1:0] mask,
  input logic [NBANK-1:0][WORD_W-1:0] sel
);

  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R1: a sampled-high source is pending at the next cycle
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> ((ipend & $past(src_i)) == $past(src_i)));

  // R1: without a write, no pending bit drops
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !bus_wr) |=> ((ipend & $past(ipend)) == $past(ipend)));

  // R3: normal line follows unmasked pending one cycle later
  a_r3_irq_comb: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> (irq_o == (|($past(ipend) & ~$past(mask)))));

  // R4: fast line follows unmasked, selected pending one cycle later
  a_r4_fiq_comb: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> (fiq_o == (|($past(ipend) & ~$past(mask) & $past(sel)))));

  // R5: vector and base reads never show the low two bits
  a_r5_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bus_rdy && $past(bus_rd) &&
     (($past(bus_addr) == 10'h000) || ($past(bus_addr) == 10'h004)))
    |-> (bus_rdata[1:0] == 2'b00));

  // R10: ready follows a strobe by one cycle
  a_r10_rdy_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> bus_rdy);

  // R10: no strobe, no ready
  a_r10_rdy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !bus_rd && !bus_wr) |=> !bus_rdy);

endmodule

bind irq_fiq_ctrl irqc_chk #(.NBANK(NBANK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .src_i     (src_i),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .bus_rdy   (bus_rdy),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .ipend     (ipend_w),
  .mask      (mask_q),
  .sel       (sel_q)
);

// File: tb/sim_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_fiq_ctrl;

  localparam int NB = 3;
  localparam int NS = NB * 32;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_i;
  logic          bus_rd, bus_wr;
  logic [9:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          bus_rdy;
  logic          irq_o, fiq_o;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  bit          q_rd[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  irq_fiq_ctrl #(.NBANK(NB)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rdy   (bus_rdy),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    q_rd.push_back(1'b0); q_exp.push_back('0); q_tag.push_back("R10 write");
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    q_rd.push_back(1'b1); q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    src_i[n] = 1'b1;
    @(negedge clk);
    src_i[n] = 1'b0;
  endtask

  task automatic chk_out(input string tag, input logic ei, input logic ef);
    chk({tag, " irq_o"}, {31'd0, irq_o}, {31'd0, ei});
    chk({tag, " fiq_o"}, {31'd0, fiq_o}, {31'd0, ef});
  endtask

  // Monitor: one scoreboard entry per completed access
  always @(negedge clk) begin
    if (rst_n && bus_rdy) begin
      if (q_rd.size() == 0) begin
        chk("R10 unexpected ready", 32'd1, 32'd0);
      end else begin
        bit          r;
        logic [31:0] e;
        string       t;
        r = q_rd.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        if (r) chk(t, bus_rdata, e);
      end
    end
  end

  initial begin
    tick(WD_CYCLES);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_i = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R9 / R10: reset state and idle bus
    chk_out("R9 reset", 1'b0, 1'b0);
    chk("R10 idle ready", {31'd0, bus_rdy}, 32'd0);
    bus_read(10'h000, 32'h0, "R9 vector reset");
    bus_read(10'h010, 32'h0, "R9 ipend reset");
    bus_read(10'h020, 32'h0, "R9 fpend reset");
    bus_read(10'h030, 32'h0, "R9 select reset");
    bus_read(10'h050, 32'h0, "R9 mask reset");

    // R5: storage and low-bit forcing
    bus_write(10'h000, 32'hDEADBEEF);
    bus_write(10'h004, 32'h12345677);
    bus_write(10'h008, 32'hFFFFFFFF);
    bus_write(10'h00C, 32'hA5A5A5A5);
    bus_write(10'h034, 32'h0F0F0F0F);
    bus_write(10'h044, 32'hCAFEF00D);
    bus_read(10'h000, 32'hDEADBEEC, "R5 vector low bits");
    bus_read(10'h004, 32'h12345674, "R5 base low bits");
    bus_read(10'h008, 32'hFFFFFFFF, "R5 protect");
    bus_read(10'h00C, 32'hA5A5A5A5, "R5 nmi");
    bus_read(10'h034, 32'h0F0F0F0F, "R5 select word1");
    bus_read(10'h030, 32'h0, "R6 select word0 untouched");
    bus_read(10'h044, 32'hCAFEF00D, "R5 enable word1");
    tick(1);
    chk_out("R12 config only", 1'b0, 1'b0);

    // R8: undecoded offsets
    bus_write(10'h03C, 32'hFFFFFFFF);
    bus_read(10'h03C, 32'h0, "R8 group offset +0xC");
    bus_read(10'h038, 32'h0, "R6 select word2 untouched");
    bus_write(10'h001, 32'h11111111);
    bus_read(10'h000, 32'hDEADBEEC, "R8 unaligned write ignored");
    bus_read(10'h060, 32'h0, "R8 read 0x60");
    bus_write(10'h100, 32'h55);
    bus_read(10'h100, 32'h0, "R8 read 0x100");

    // R1 / R3 / R4 / R7: source 40 = word1 bit8, routed to fast line
    pulse(40);
    tick(1);
    chk_out("R3 R4 source 40", 1'b1, 1'b1);
    bus_read(10'h014, 32'h0000_0100, "R1 sticky word1");
    bus_read(10'h010, 32'h0, "R6 ipend word0");
    bus_read(10'h024, 32'h0000_0100, "R7 fpend word1");
    bus_read(10'h020, 32'h0, "R7 fpend word0");

    // R3 mask, R12 enable
    bus_write(10'h054, 32'h0000_0100);
    tick(1);
    chk_out("R3 masked", 1'b0, 1'b0);
    bus_write(10'h044, 32'hFFFFFFFF);
    tick(1);
    chk_out("R12 enable set", 1'b0, 1'b0);
    bus_write(10'h054, 32'h0);
    tick(1);
    chk_out("R3 unmasked", 1'b1, 1'b1);
    bus_write(10'h044, 32'h0);
    tick(1);
    chk_out("R12 enable clear", 1'b1, 1'b1);

    // R4: unroute
    bus_write(10'h034, 32'h0);
    tick(1);
    chk_out("R4 unrouted", 1'b1, 1'b0);

    // R2: write-one-to-clear
    bus_write(10'h014, 32'h0);
    bus_read(10'h014, 32'h0000_0100, "R2 zeros keep");
    bus_write(10'h014, 32'hFFFF_FEFF);
    bus_read(10'h014, 32'h0000_0100, "R2 other ones");
    bus_write(10'h014, 32'h0000_0100);
    tick(1);
    chk_out("R2 cleared", 1'b0, 1'b0);
    bus_read(10'h014, 32'h0, "R2 cleared word");
    bus_read(10'h024, 32'h0000_0100, "R7 independent of ipend");
    bus_write(10'h024, 32'h0000_0100);
    bus_read(10'h024, 32'h0, "R7 fpend cleared");

    // R7: unrouted capture leaves fpend clear
    pulse(41);
    bus_read(10'h024, 32'h0, "R7 unrouted no fpend");
    bus_read(10'h014, 32'h0000_0200, "R1 source 41");
    bus_write(10'h014, 32'h0000_0200);

    // R11: set and clear in the same cycle
    @(negedge clk);
    src_i[0] = 1'b1;
    bus_wr = 1'b1; bus_addr = 10'h010; bus_wdata = 32'h1;
    q_rd.push_back(1'b0); q_exp.push_back('0); q_tag.push_back("R10 write");
    @(negedge clk);
    src_i[0] = 1'b0; bus_wr = 1'b0;
    bus_read(10'h010, 32'h1, "R11 set wins");
    chk_out("R11 line", 1'b1, 1'b0);
    bus_write(10'h010, 32'h1);
    bus_read(10'h010, 32'h0, "R2 word0 cleared");
    tick(1);
    chk_out("R2 lines low", 1'b0, 1'b0);

    // R1: highest source
    pulse(95);
    tick(1);
    chk_out("R1 source 95", 1'b1, 1'b0);
    bus_read(10'h018, 32'h8000_0000, "R1 word2 bit31");

    // R9: reset mid-run
    tick(2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_out("R9 reset asserted", 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(3);
    bus_read(10'h018, 32'h0, "R9 ipend cleared");
    bus_read(10'h000, 32'h0, "R9 vector cleared");
    bus_read(10'h008, 32'h0, "R9 protect cleared");
    bus_read(10'h00C, 32'h0, "R9 nmi cleared");
    tick(3);
    chk("R10 scoreboard drained", q_rd.size(), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule